// File: doc/BRIEF.md
# ACK Airtime Duration Table Generator

This block fills a small table with the on-air time, in microseconds, of a 10-byte acknowledgement frame. There is one entry for each of twelve transmit rate indices: four CCK indices followed by eight OFDM indices. A one-cycle start pulse launches a run. For each index the sequencer picks the rate the acknowledgement would be sent at. It then counts the OFDM symbols needed with a sequential restoring divider, which rounds up. It adds the inter-frame space and preamble for the selected channel bandwidth mode, and writes the result into a register file. The three short-preamble-capable indices get a second copy of their entry in a separate slot.

Software or a neighbouring MAC block reads the table through a combinational read port once `done` has pulsed. All pins are plain control and status signals. The read port has no handshake: the entry at `rd_addr` is on `rd_data` in the same cycle, so there is no back-pressure to manage.

Top module: `ackdur_gen`

## Requirements
- R1: After reset, `busy` and `done` are low and every table address (0 to 15) reads zero.
- R2: A `start` pulse seen while `busy` is low begins a run: `busy` is high from the next cycle. A `start` seen while `busy` is high has no effect, so the run's timing and results are unchanged.
- R3: A run takes 12×(16+2)+3 = 219 cycles with the default 16-bit divider. `done` is high for exactly one cycle, directly after the last table write. `busy` falls on the same edge that raises `done`. A `start` in that `done` cycle is accepted.
- R4: Each entry equals SIFS + preamble + symbol_time × ceil(((22 + 8×10) × 10) / (rate_in_100kbps × symbol_time)). In the default mode this uses a 4 µs symbol, a 16 µs preamble and a 16 µs SIFS, so the 1 Mb/s entry is 136.
- R5: `bw_mode` encoding: 0 is default timing. 1 is 40 MHz: 8 µs SIFS, 14 µs preamble, 4 µs symbol. 2 is 10 MHz: preamble and symbol doubled, 32 µs SIFS. 3 is 5 MHz: preamble and symbol quadrupled, 64 µs SIFS.
- R6: With `high_ack` set, transmit index i (rates 1, 2, 5.5, 11, 6, 9, 12, 18, 24, 36, 48, 54 Mb/s for i = 0..11) uses the acknowledgement rate of index 0, 1, 1, 1, 4, 4, 6, 6, 8, 8, 8, 8.
- R7: With `high_ack` clear, indices 0 to 3 use the 1 Mb/s rate and indices 4 to 11 use the 6 Mb/s rate.
- R8: Addresses 0 to 11 hold the entries for indices 0 to 11. Addresses 13, 14 and 15 hold copies of entries 1, 2 and 3. Address 12 always reads zero.
- R9: An entry whose value exceeds 65535 is stored as 65535.
- R10: `bw_mode` and `high_ack` are captured when a run starts. Changes during the run do not affect its results.
- R11: `rd_data` shows the entry at `rd_addr` in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a table run when idle |
| bw_mode | input | 2 | Channel bandwidth mode, captured at start |
| high_ack | input | 1 | Use the rate-dependent acknowledgement map |
| rd_addr | input | 4 | Table read address |
| rd_data | output | 16 | Table entry at `rd_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Two functions can fall in the same cycle. The first is the end of a run, when `done` is high and `busy` has just fallen, together with the acceptance of the next `start`. The bench raises `start` in the very cycle it sees `done`. Its per-clock model then expects `done` to clear and `busy` to rise on the following edge, and the second run's table must reflect the newly captured mode. The second case is a mid-run `start` together with a change of the mode inputs. Both must leave the cycle count and every table value unchanged from the captured configuration.

// File: rtl/ackdur_pkg.sv
package ackdur_pkg;

  localparam int N_RATES = 12;
  localparam int N_SLOTS = 16;
  localparam int SLOT_AW = 4;

  typedef enum logic [1:0] {
    BW_STD     = 2'd0,
    BW_TURBO   = 2'd1,
    BW_HALF    = 2'd2,
    BW_QUARTER = 2'd3
  } bw_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT,
    SQ_SHORT
  } seq_state_e;

  // Transmit rate of a table index, in units of 100 kbit/s.
  function automatic int unsigned rate_x100k(input logic [SLOT_AW-1:0] i);
    case (i)
      4'd0:    return 10;
      4'd1:    return 20;
      4'd2:    return 55;
      4'd3:    return 110;
      4'd4:    return 60;
      4'd5:    return 90;
      4'd6:    return 120;
      4'd7:    return 180;
      4'd8:    return 240;
      4'd9:    return 360;
      4'd10:   return 480;
      default: return 540;
    endcase
  endfunction

  // Index whose rate carries the acknowledgement for transmit index tx.
  function automatic logic [SLOT_AW-1:0] ack_index(input logic [SLOT_AW-1:0] tx,
                                                   input logic hi);
    if (!hi) return (tx < 4'd4) ? 4'd0 : 4'd4;
    if (tx == 4'd0) return 4'd0;
    if (tx < 4'd4)  return 4'd1;
    if (tx < 4'd6)  return 4'd4;
    if (tx < 4'd8)  return 4'd6;
    return 4'd8;
  endfunction

  function automatic logic short_capable(input logic [SLOT_AW-1:0] i);
    return (i >= 4'd1) && (i <= 4'd3);
  endfunction

endpackage

// File: rtl/ackdur_timing.sv
module ackdur_timing
  import ackdur_pkg::*;
#(
  parameter int OPW        = 16,
  parameter int LEN_BYTES  = 10,
  parameter int PLCP_BITS  = 22,
  parameter int SYM_US     = 4,
  parameter int PRE_US     = 16,
  parameter int SIFS_US    = 16,
  parameter int TURBO_SIFS = 8,
  parameter int MIN_PRE_US = 14,
  parameter int HALF_SIFS  = 32,
  parameter int QUART_SIFS = 64
) (
  input  bw_mode_e             mode,
  input  logic                 hi,
  input  logic [SLOT_AW-1:0]   idx,
  output logic [OPW-1:0]       num,
  output logic [OPW-1:0]       den,
  output logic [31:0]          base_us,
  output logic [31:0]          sym_us
);
  localparam int NUM10 = (PLCP_BITS + 8 * LEN_BYTES) * 10;

  logic [31:0] sym_v, pre_v, ifs_v, rate_v, den_v;

  always_comb begin
    case (mode)
      BW_TURBO: begin
        sym_v = 32'(SYM_US);
        pre_v = 32'(MIN_PRE_US);
        ifs_v = 32'(TURBO_SIFS);
      end
      BW_HALF: begin
        sym_v = 32'(2 * SYM_US);
        pre_v = 32'(2 * PRE_US);
        ifs_v = 32'(HALF_SIFS);
      end
      BW_QUARTER: begin
        sym_v = 32'(4 * SYM_US);
        pre_v = 32'(4 * PRE_US);
        ifs_v = 32'(QUART_SIFS);
      end
      default: begin
        sym_v = 32'(SYM_US);
        pre_v = 32'(PRE_US);
        ifs_v = 32'(SIFS_US);
      end
    endcase
    rate_v  = rate_x100k(ack_index(idx, hi));
    den_v   = rate_v * sym_v;
    den     = den_v[OPW-1:0];
    num     = OPW'(NUM10);
    base_us = ifs_v + pre_v;
    sym_us  = sym_v;
  end

endmodule

// File: rtl/ackdur_divider.sv
module ackdur_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         valid,
  output logic [W-1:0] quotient,
  output logic         rem_nz
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = shifted >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
    end else if (go) begin
      rem_q <= '0;
      quo_q <= dividend;
      cnt_q <= CW'(W);
      valid <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q <= fits ? W'(shifted - {1'b0, divisor}) : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      valid <= (cnt_q == CW'(1));
    end else begin
      valid <= 1'b0;
    end
  end

  assign quotient = quo_q;
  assign rem_nz   = rem_q != '0;

endmodule

// File: rtl/ackdur_regfile.sv
module ackdur_regfile #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          slot_q <= '0;
      else if (we && waddr == AW'(g))      slot_q <= wdata;
    end
    assign slots[g] = slot_q;
  end

  assign rdata = slots[raddr];

endmodule

// File: rtl/ackdur_gen.sv
module ackdur_gen
  import ackdur_pkg::*;
#(
  parameter int DUR_W      = 16,
  parameter int OPW        = 16,
  parameter int LEN_BYTES  = 10,
  parameter int PLCP_BITS  = 22,
  parameter int SYM_US     = 4,
  parameter int PRE_US     = 16,
  parameter int SIFS_US    = 16,
  parameter int TURBO_SIFS = 8,
  parameter int MIN_PRE_US = 14,
  parameter int HALF_SIFS  = 32,
  parameter int QUART_SIFS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         bw_mode,
  input  logic               high_ack,
  input  logic [SLOT_AW-1:0] rd_addr,
  output logic [DUR_W-1:0]   rd_data,
  output logic               busy,
  output logic               done
);
  localparam logic [SLOT_AW-1:0] LAST_IDX   = SLOT_AW'(N_RATES - 1);
  localparam logic [SLOT_AW-1:0] SHORT_BASE = SLOT_AW'(N_RATES);
  localparam logic [31:0]        DUR_MAX    = 32'((64'd1 << DUR_W) - 1);

  seq_state_e         state_q;
  bw_mode_e           mode_q;
  logic               hi_q;
  logic [SLOT_AW-1:0] idx_q;
  logic [DUR_W-1:0]   dur_q;

  logic [OPW-1:0]     num, den, quo;
  logic [31:0]        base_us, sym_us, dur_full;
  logic               div_start, div_valid, rem_nz;
  logic [DUR_W-1:0]   dur_sat;
  logic               wr_en;
  logic [SLOT_AW-1:0] wr_addr;
  logic [DUR_W-1:0]   wr_data;
  logic               last_write;

  ackdur_timing #(
    .OPW(OPW), .LEN_BYTES(LEN_BYTES), .PLCP_BITS(PLCP_BITS),
    .SYM_US(SYM_US), .PRE_US(PRE_US), .SIFS_US(SIFS_US),
    .TURBO_SIFS(TURBO_SIFS), .MIN_PRE_US(MIN_PRE_US),
    .HALF_SIFS(HALF_SIFS), .QUART_SIFS(QUART_SIFS)
  ) u_timing (
    .mode(mode_q), .hi(hi_q), .idx(idx_q),
    .num(num), .den(den), .base_us(base_us), .sym_us(sym_us)
  );

  assign div_start = state_q == SQ_LAUNCH;

  ackdur_divider #(.W(OPW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_start),
    .dividend(num), .divisor(den),
    .valid(div_valid), .quotient(quo), .rem_nz(rem_nz)
  );

  // Round the symbol count up, then saturate to the entry width.
  assign dur_full = base_us + sym_us * (32'(quo) + 32'(rem_nz));
  assign dur_sat  = (dur_full > DUR_MAX) ? '1 : dur_full[DUR_W-1:0];

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = idx_q;
    wr_data = dur_sat;
    if (state_q == SQ_WAIT && div_valid) begin
      wr_en = 1'b1;
    end else if (state_q == SQ_SHORT) begin
      wr_en   = 1'b1;
      wr_addr = SHORT_BASE + idx_q;
      wr_data = dur_q;
    end
  end

  assign last_write = wr_en && (idx_q == LAST_IDX) &&
                      !(state_q == SQ_WAIT && short_capable(idx_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= BW_STD;
      hi_q    <= 1'b0;
      idx_q   <= '0;
      dur_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            mode_q  <= bw_mode_e'(bw_mode);
            hi_q    <= high_ack;
            idx_q   <= '0;
            busy    <= 1'b1;
            state_q <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (div_valid) begin
            dur_q <= dur_sat;
            if (short_capable(idx_q)) begin
              state_q <= SQ_SHORT;
            end else if (last_write) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              state_q <= SQ_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SQ_LAUNCH;
            end
          end
        end
        default: begin
          if (last_write) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SQ_LAUNCH;
          end
        end
      endcase
    end
  end

  ackdur_regfile #(.DW(DUR_W), .AW(SLOT_AW), .DEPTH(N_SLOTS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

endmodule

// File: rtl/ackdur_chk.sv
module ackdur_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic          div_start,
  input logic          div_valid,
  input logic [1:0]    cfg_mode,
  input logic          cfg_hi,
  input logic [3:0]    rd_addr,
  input logic [DW-1:0] rd_data
);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_mode) && $stable(cfg_hi)));

  // R3
  div_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> !div_valid);

  // R8
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 4'd12) |-> (rd_data == '0));

endmodule

bind ackdur_gen ackdur_chk #(.DW(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .div_start(div_start), .div_valid(div_valid),
  .cfg_mode(mode_q), .cfg_hi(hi_q), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_ackdur_gen.sv
`timescale 1ns/1ps
module sim_ackdur_gen;

  localparam int RUN_CYC = 12 * (16 + 2) + 3;
  localparam int BIG_SIFS = 65500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start1 = 1'b0;
  logic [1:0]  bw_mode = 2'd0;
  logic        high_ack = 1'b0;
  logic [3:0]  rd_addr = 4'd0;
  logic [15:0] rd_data, rd_data1;
  logic        busy, done, busy1, done1;

  int errs = 0;
  int checks = 0;
  int m_rem = 0;
  bit m_done = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  ackdur_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bw_mode(bw_mode),
    .high_ack(high_ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  ackdur_gen #(.SIFS_US(BIG_SIFS)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .bw_mode(bw_mode),
    .high_ack(high_ack), .rd_addr(rd_addr), .rd_data(rd_data1),
    .busy(busy1), .done(done1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Requirement-level model of an entry.
  function automatic int exp_dur(input int i, input int mode, input bit hi, input int sifs_std);
    int rt[12] = '{10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480, 540};
    int hm[12] = '{0, 1, 1, 1, 4, 4, 6, 6, 8, 8, 8, 8};
    int a, sym, pre, ifs, num, den, q, d;
    a = hi ? hm[i] : ((i < 4) ? 0 : 4);
    case (mode)
      1: begin sym = 4;  pre = 14; ifs = 8;  end
      2: begin sym = 8;  pre = 32; ifs = 32; end
      3: begin sym = 16; pre = 64; ifs = 64; end
      default: begin sym = 4; pre = 16; ifs = sifs_std; end
    endcase
    num = (22 + 8 * 10) * 10;
    den = rt[a] * sym;
    q = (num + den - 1) / den;
    d = ifs + pre + sym * q;
    return (d > 65535) ? 65535 : d;
  endfunction

  function automatic int exp_slot(input int addr, input int mode, input bit hi, input int sifs_std);
    if (addr < 12) return exp_dur(addr, mode, hi, sifs_std);
    if (addr == 12) return 0;
    return exp_dur(addr - 12, mode, hi, sifs_std);
  endfunction

  // Cycle model of busy/done for u0 (R2, R3).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0;
      m_done = 0;
    end else begin
      m_done = 0;
      if (start && m_rem == 0) m_rem = RUN_CYC;
      else if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) m_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      #1;
      chk("R2 busy", int'(busy), int'(m_rem > 0));
      chk("R3 done", int'(done), int'(m_done));
    end
  end

  task automatic check_table(input string req, input int mode, input bit hi);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      chk(req, int'(rd_data), exp_slot(a, mode, hi, 16));
    end
  endtask

  task automatic pulse_start(input int mode, input bit hi);
    bw_mode = 2'(mode);
    high_ack = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    while (!done) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    checks++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      chk("R1 table", int'(rd_data), 0);
    end

    // R4 R7 R8 R11: default timing, base acknowledgement rates
    @(negedge clk);
    pulse_start(0, 1'b0);
    wait_done();
    rd_addr = 4'd0;
    #1;
    chk("R4 1Mb entry", int'(rd_data), 136);
    check_table("R7 default/low", 0, 1'b0);

    // R6 R2 R10: high map; mid-run start and config change ignored
    @(negedge clk);
    pulse_start(0, 1'b1);
    repeat (40) @(negedge clk);
    bw_mode = 2'd3;
    high_ack = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_table("R6 R10 default/high", 0, 1'b1);

    // R5: 10 MHz with high map, then back-to-back 5 MHz in the done cycle
    @(negedge clk);
    pulse_start(2, 1'b1);
    wait_done();
    // R3: start arriving in the done cycle
    pulse_start(3, 1'b0);
    wait_done();
    check_table("R5 quarter/low", 3, 1'b0);

    // R5: 40 MHz timing
    @(negedge clk);
    pulse_start(1, 1'b1);
    wait_done();
    check_table("R5 turbo/high", 1, 1'b1);

    @(negedge clk);
    pulse_start(2, 1'b0);
    wait_done();
    check_table("R5 half/low", 2, 1'b0);

    // R9: saturating instance
    @(negedge clk);
    bw_mode = 2'd0;
    high_ack = 1'b0;
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    while (!done1) @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      chk("R9 saturate", int'(rd_data1), exp_slot(a, 0, 1'b0, BIG_SIFS));
    end

    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule